// File: doc/BRIEF.md
# Peripheral Rate Control Gate

This block holds the flow-control state that a DMA transfer engine consults before it moves data to or from a peripheral. Each of sixteen client slots has a request line, a stored block-size code and a mux-select flag. When a client raises its request line, the slot arms a pending flag. Each armed flag lets the engine move exactly one block of data.

The transfer engine issues a query. A query carries a source-side client index, a destination-side client index and a direction bit. The direction picks which index applies. The gate replies in the same cycle with a grant, the block length in bytes, an error flag for an unusable size code, the slot's mux-select flag and a bypass flag. A query that is granted against a real slot consumes that slot's pending flag at the next clock edge. Index zero is not a throttled client: a query that selects it is always granted and leaves every slot untouched.

Software programs the slots through a simple write port. One 32-bit control word goes to one slot per write. A control word can also carry a self-clearing soft-reset bit, which drops the slot's pending flag.

Top module: `flow_gate`

## Requirements
- R1: Control word bits [2:0] hold the block-size code. For a non-reserved code, the reported length q_len_o is 16, 32, 64, 128, 192 or 256 bytes for codes 0 through 5 respectively.
- R2: Codes 6 and 7 are reserved. A valid query that selects a slot holding a reserved code drives q_err_o=1, q_grant_o=0 and q_len_o=0. The slot's pending flag stays set.
- R3: A 0-to-1 transition of req_i[k] sets the pending flag of slot k at the next clock edge. Holding req_i[k] high does not arm the slot a second time.
- R4: A valid query that is granted against slot k (k not zero) clears slot k's pending flag at the clock edge that ends the query. A second query then gets q_grant_o=0, so each request allows exactly one block.
- R5: When the selected index is 0, a valid query gives q_grant_o=1, q_bypass_o=1, q_len_o=0, q_err_o=0 and q_mux_o=0, whatever is stored in slot 0. It consumes no slot's pending flag.
- R6: With q_to_mem_i=1 (peripheral to memory), the query uses q_src_idx_i. With q_to_mem_i=0 (memory to peripheral), it uses q_dst_idx_i.
- R7: A write whose bit 17 is 1 clears the addressed slot's pending flag. This takes priority over a rising request in the same cycle. The write still stores the code and the mux bit it carries.
- R8: Bit 18 of the control word is stored as the slot's mux-select flag. It is reported on q_mux_o for a valid, non-bypassed query.
- R9: Suppose a rising request on slot k arrives in the same cycle as the grant that consumes slot k. The new request is kept, and the next query on slot k is granted.
- R10: After reset, every pending flag is clear, every slot holds code 0 and mux-select 0. A valid query to a nonzero slot returns q_grant_o=0, q_err_o=0 and q_len_o=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 16 | Per-client request lines; a rising edge arms one block |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_idx_i | input | 4 | Slot addressed by the write |
| cfg_data_i | input | 32 | Control word: [2:0] size code, [17] soft reset, [18] mux select |
| q_valid_i | input | 1 | Query present this cycle |
| q_src_idx_i | input | 4 | Source-side client index |
| q_dst_idx_i | input | 4 | Destination-side client index |
| q_to_mem_i | input | 1 | 1: peripheral to memory (source index); 0: memory to peripheral (destination index) |
| q_grant_o | output | 1 | One block may be moved |
| q_len_o | output | 9 | Block length in bytes (0 for bypass or reserved code) |
| q_err_o | output | 1 | Selected slot holds a reserved size code |
| q_mux_o | output | 1 | Mux-select flag of the selected slot |
| q_bypass_o | output | 1 | Selected index is 0; no flow control applied |

## Verification
Two pairs of functions can act on the same slot in the same clock edge. First, a new rising request can land on the edge where a granted query consumes the previous block. Second, a soft-reset write can land on the edge where a request rises. The bench provokes both from one negative edge. For the first pair, it drives the query and the request edge together. For the second, it drives the write and the request edge together. It then queries the slot once the edge has passed. The first case must still grant, because the fresh request survives the consumption. The second must refuse, because the clear wins over the new request.

// File: rtl/flow_gate_pkg.sv
package flow_gate_pkg;
  localparam int CODE_W   = 3;
  localparam int LEN_W    = 9;
  localparam int WORD_W   = 32;
  localparam int SRST_BIT = 17;
  localparam int MUX_BIT  = 18;
  localparam int UNIT_LEN = 16;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              mux;
  } slot_cfg_t;
endpackage

// File: rtl/fg_size_decode.sv
module fg_size_decode
  import flow_gate_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              reserved_o
);
  always_comb begin
    reserved_o = 1'b0;
    len_o      = '0;
    case (code_i)
      3'd0, 3'd1, 3'd2, 3'd3: len_o = LEN_W'(UNIT_LEN) << code_i;
      3'd4:                   len_o = LEN_W'(192);
      3'd5:                   len_o = LEN_W'(256);
      default:                reserved_o = 1'b1;
    endcase
  end

  always_comb begin
    if (!reserved_o) begin
      assert_len_legal_R1: assert (len_o != '0 && len_o[3:0] == 4'd0);
    end
  end
endmodule

// File: rtl/fg_slot_cfg.sv
module fg_slot_cfg
  import flow_gate_pkg::*;
#(
  parameter int NUM_CLIENTS = 16,
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [WORD_W-1:0]           data_i,
  output slot_cfg_t [NUM_CLIENTS-1:0] cfg_o,
  output logic [NUM_CLIENTS-1:0]      clear_o
);
  slot_cfg_t [NUM_CLIENTS-1:0] cfg_q, cfg_d;
  logic [NUM_CLIENTS-1:0]      slot_en;

  for (genvar k = 0; k < NUM_CLIENTS; k++) begin : g_slot
    assign slot_en[k] = we_i && (idx_i == IDX_W'(k));
    assign clear_o[k] = slot_en[k] && data_i[SRST_BIT];

    always_comb begin
      cfg_d[k] = cfg_q[k];
      if (slot_en[k]) begin
        cfg_d[k].code = data_i[CODE_W-1:0];
        cfg_d[k].mux  = data_i[MUX_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[k] <= '0;
      else if (slot_en[k]) cfg_q[k] <= cfg_d[k];
    end

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_en[k] |=> (cfg_q[k].mux == $past(data_i[MUX_BIT])));
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/fg_req_capture.sv
module fg_req_capture #(
  parameter int NUM_CLIENTS = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] req_i,
  input  logic [NUM_CLIENTS-1:0] consume_i,
  input  logic [NUM_CLIENTS-1:0] clear_i,
  output logic [NUM_CLIENTS-1:0] pending_o
);
  logic [NUM_CLIENTS-1:0] req_q, pend_q, pend_d, rise;

  assign rise = req_i & ~req_q;

  for (genvar k = 0; k < NUM_CLIENTS; k++) begin : g_pend
    always_comb begin
      pend_d[k] = pend_q[k];
      if (clear_i[k])        pend_d[k] = 1'b0;
      else if (rise[k])      pend_d[k] = 1'b1;
      else if (consume_i[k]) pend_d[k] = 1'b0;
    end

    assert_rise_arms_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(req_i[k]) && !clear_i[k]) |=> pend_q[k]);
    assert_grant_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (consume_i[k] && !clear_i[k] && !$rose(req_i[k])) |=> !pend_q[k]);
    assert_srst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i[k] |=> !pend_q[k]);
    assert_race_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (consume_i[k] && $rose(req_i[k]) && !clear_i[k]) |=> pend_q[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/flow_gate.sv
module flow_gate
  import flow_gate_pkg::*;
#(
  parameter int NUM_CLIENTS = 16,
  parameter int IDX_W       = $clog2(NUM_CLIENTS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CLIENTS-1:0] req_i,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_idx_i,
  input  logic [WORD_W-1:0]      cfg_data_i,
  input  logic                   q_valid_i,
  input  logic [IDX_W-1:0]       q_src_idx_i,
  input  logic [IDX_W-1:0]       q_dst_idx_i,
  input  logic                   q_to_mem_i,
  output logic                   q_grant_o,
  output logic [LEN_W-1:0]       q_len_o,
  output logic                   q_err_o,
  output logic                   q_mux_o,
  output logic                   q_bypass_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  slot_cfg_t [NUM_CLIENTS-1:0] slot_cfg;
  logic [NUM_CLIENTS-1:0]      slot_clear, pending, consume;
  logic [IDX_W-1:0]            sel_idx;
  logic                        sel_zero, sel_pend, sel_rsvd, block_grant;
  logic [LEN_W-1:0]            sel_len;

  fg_slot_cfg #(.NUM_CLIENTS(NUM_CLIENTS), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we_i(cfg_we_i), .idx_i(cfg_idx_i),
    .data_i(cfg_data_i), .cfg_o(slot_cfg), .clear_o(slot_clear)
  );

  fg_req_capture #(.NUM_CLIENTS(NUM_CLIENTS)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .req_i(req_i), .consume_i(consume),
    .clear_i(slot_clear), .pending_o(pending)
  );

  assign sel_idx  = q_to_mem_i ? q_src_idx_i : q_dst_idx_i;
  assign sel_zero = (sel_idx == '0);
  assign sel_pend = pending[sel_idx];

  fg_size_decode u_dec (
    .code_i(slot_cfg[sel_idx].code), .len_o(sel_len), .reserved_o(sel_rsvd)
  );

  assign block_grant = q_valid_i && !sel_zero && sel_pend && !sel_rsvd;

  always_comb begin
    consume = '0;
    if (block_grant) consume[sel_idx] = 1'b1;
  end

  assign q_bypass_o = q_valid_i && sel_zero;
  assign q_grant_o  = q_bypass_o || block_grant;
  assign q_err_o    = q_valid_i && !sel_zero && sel_rsvd;
  assign q_len_o    = (q_valid_i && !sel_zero) ? sel_len : '0;
  assign q_mux_o    = q_valid_i && !sel_zero && slot_cfg[sel_idx].mux;

  assert_bypass_free_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    q_bypass_o |-> (q_grant_o && q_len_o == '0 && !q_err_o && consume == '0));
  assert_err_blocks_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    q_err_o |-> (!q_grant_o && q_len_o == '0));
  assert_one_block_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(consume));
  assert_grant_needs_pend_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (q_grant_o && !q_bypass_o) |-> pending[sel_idx]);
endmodule

// File: tb/tb_flow_gate.sv
`timescale 1ns/1ps
module tb_flow_gate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_data;
  logic        q_valid, q_to_mem;
  logic [3:0]  q_src, q_dst;
  logic        q_grant, q_err, q_mux, q_bypass;
  logic [8:0]  q_len;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flow_gate dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_data_i(cfg_data), .q_valid_i(q_valid), .q_src_idx_i(q_src),
    .q_dst_idx_i(q_dst), .q_to_mem_i(q_to_mem), .q_grant_o(q_grant),
    .q_len_o(q_len), .q_err_o(q_err), .q_mux_o(q_mux), .q_bypass_o(q_bypass)
  );

  // {code, expected length, expected error}
  localparam logic [12:0] VEC [0:7] = '{
    {3'd0, 9'd16,  1'b0}, {3'd1, 9'd32,  1'b0}, {3'd2, 9'd64,  1'b0},
    {3'd3, 9'd128, 1'b0}, {3'd4, 9'd192, 1'b0}, {3'd5, 9'd256, 1'b0},
    {3'd6, 9'd0,   1'b1}, {3'd7, 9'd0,   1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int k);
    @(negedge clk); req[k] = 1'b1;
    @(negedge clk); req[k] = 1'b0;
  endtask

  // present a query at a falling edge and let outputs settle
  task automatic ask(input int src, input int dst, input logic to_mem);
    @(negedge clk);
    q_valid = 1'b1; q_src = 4'(src); q_dst = 4'(dst); q_to_mem = to_mem;
    #1;
  endtask

  task automatic drop();
    q_valid = 1'b0;
  endtask

  task automatic take();
    @(posedge clk); #1; q_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
    q_valid = 1'b0; q_src = '0; q_dst = '0; q_to_mem = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: reset state
    ask(0, 3, 1'b0);
    chk("R10 grant", q_grant, 0); chk("R10 len", q_len, 16);
    chk("R10 err", q_err, 0);     chk("R10 mux", q_mux, 0);
    drop();

    // R1/R2: table walk over all codes on slot 3
    for (int i = 0; i < 8; i++) begin
      wr(3, {29'd0, VEC[i][12:10]});
      pulse(3);
      ask(0, 3, 1'b0);
      chk("R1 len", q_len, int'(VEC[i][9:1]));
      chk("R2 err", q_err, int'(VEC[i][0]));
      chk("R2 grant", q_grant, int'(!VEC[i][0]));
      take();
      if (!VEC[i][0]) begin
        ask(0, 3, 1'b0);
        chk("R4 second query", q_grant, 0);
        drop();
      end
    end
    // R2: reserved code left pending armed; a legal code now grants
    wr(3, 32'd1);
    ask(0, 3, 1'b0);
    chk("R2 pending kept", q_grant, 1);
    drop();

    // R7: soft reset clears pending, stores new code
    wr(3, (32'd1 << 17) | 32'd2);
    ask(0, 3, 1'b0);
    chk("R7 cleared", q_grant, 0); chk("R7 code stored", q_len, 64);
    drop();

    // R3/R6: level held grants once; source index on peripheral-to-memory
    @(negedge clk); req[4] = 1'b1;
    ask(4, 9, 1'b1);
    chk("R3 armed via src R6", q_grant, 1);
    take();
    repeat (2) @(posedge clk);
    ask(4, 9, 1'b1);
    chk("R3 no re-arm on level", q_grant, 0);
    drop();
    @(negedge clk); req[4] = 1'b0;

    // R6: direction selects the index
    pulse(4);
    ask(7, 4, 1'b1);
    chk("R6 src picked", q_grant, 0);
    drop();
    ask(7, 4, 1'b0);
    chk("R6 dst picked", q_grant, 1);
    drop();

    // R5: bypass on index 0, slot 0 holding a reserved code and mux set
    wr(0, (32'd1 << 18) | 32'd7);
    ask(4, 0, 1'b0);
    chk("R5 grant", q_grant, 1); chk("R5 bypass", q_bypass, 1);
    chk("R5 len", q_len, 0);     chk("R5 err", q_err, 0);
    chk("R5 mux", q_mux, 0);
    take();
    ask(0, 4, 1'b0);
    chk("R5 slot 4 untouched", q_grant, 1);
    take();

    // R8: mux-select flag
    wr(6, (32'd1 << 18) | 32'd5);
    ask(0, 6, 1'b0);
    chk("R8 mux set", q_mux, 1); chk("R8 len", q_len, 256);
    drop();
    wr(6, 32'd5);
    ask(0, 6, 1'b0);
    chk("R8 mux clear", q_mux, 0);
    drop();

    // R9: new request in the grant cycle is kept
    pulse(5);
    @(negedge clk);
    q_valid = 1'b1; q_src = '0; q_dst = 4'd5; q_to_mem = 1'b0; req[5] = 1'b1;
    #1 chk("R9 first grant", q_grant, 1);
    take();
    ask(0, 5, 1'b0);
    chk("R9 request kept", q_grant, 1);
    take();
    ask(0, 5, 1'b0);
    chk("R9 then consumed", q_grant, 0);
    drop();
    req[5] = 1'b0;

    // R7: soft reset beats a same-cycle rise
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd8; cfg_data = 32'd1 << 17; req[8] = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    ask(0, 8, 1'b0);
    chk("R7 clear wins", q_grant, 0);
    drop();
    req[8] = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule